// File: doc/BRIEF.md
# Two-Wire Register-Window Slave with Auto-Incrementing Pointer

This block is the serial front end of a timekeeping register bank. It watches a two-wire serial bus through its system clock, detects START and STOP conditions, answers one fixed device address and then moves bytes between the bus and an external register file of 160 locations. An internal word pointer selects the location. The first byte after a write address loads the pointer, and every data byte moves it forward by one. Writes go out as single-cycle strobes. Reads fetch from the register file through an address/data pair.

The location space has fixed zones. Locations 00h to 07h hold the running clock. 16h to 1Dh hold a read-only serial number. 10h to 12h and 1Eh to 1Fh are unused, and 20h to 9Fh are general storage. The controller guards these zones itself: unused locations read as zero, and unused and serial-number locations are never written. While an addressed access sits on the clock locations, the controller raises a hold request so that the clock block keeps its visible copy still. A power-fail input aborts everything and parks the pointer at zero.

The block only pulls SDA low, through an output-enable, so it fits an open-drain pad.

Top module: `rtcbus_slave`

## Requirements
- R1: The 7-bit device address is 1101000b, sent as byte D0h to write or D1h to read (bit 0 = 1 means read). The slave acknowledges it by pulling SDA low during the ninth clock. For any other address it leaves SDA released, and it ignores the rest of that transaction until the next START or STOP.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START received at any point, including a repeated START, begins a new address phase. A STOP returns the slave to idle.
- R3: In a write transaction the first byte after D0h loads the pointer. Each later byte is issued as a one-cycle reg_we strobe, with reg_addr equal to the pointer and reg_wdata equal to the byte. The slave acknowledges the word address and every data byte.
- R4: The pointer advances by one on the acknowledge clock that follows each data byte, in both directions. This includes a read byte that the master does not acknowledge. It does not advance after the word address.
- R5: A read transaction (D1h) returns the byte at the pointer, MSB first. Each byte the master acknowledges is followed by the byte at the next location.
- R6: A read that is not preceded by a pointer write starts at the pointer value left by the last access.
- R7: The pointer wraps from 9Fh to 00h. A word address above 9Fh loads 00h, so reg_addr never exceeds 9Fh.
- R8: Reads of locations 10h to 12h and 1Eh to 1Fh return 00h, whatever reg_rdata holds. Serial-number locations 16h to 1Dh read normally.
- R9: Writes aimed at 10h to 12h and 16h to 1Fh produce no reg_we strobe, but the pointer still advances.
- R10: When the master answers a read byte with NACK, the slave releases SDA and ignores further clocks until a START or STOP.
- R11: clk_hold is high while an addressed access is open and the pointer is within 00h to 07h. It drops after a STOP, or once the pointer moves past 07h.
- R12: While pwr_fail is high, the cycle after it is seen has SDA released, the pointer at 00h and no write strobes. clk_hold drops, and bus activity is neither acknowledged nor acted on until pwr_fail falls.
- R13: After reset sda_oe, reg_we and clk_hold are low and reg_addr is 00h. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| pwr_fail | input | 1 | Supply out of tolerance, synchronous to clk |
| reg_addr | output | AW (8) | Register-file location, equal to the word pointer |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Register-file contents at reg_addr |
| clk_hold | output | 1 | Asks the clock block to freeze its visible copy |

## Verification
Write bursts, random reads with a repeated START and current-address reads are run back to back. This separates a pointer that steps on the acknowledge clock from one that steps elsewhere or skips the final NACKed byte. A wrong device address, a NACK followed by extra clocks, and an oversize word address show whether the slave really stops driving and clamps its pointer. Accesses at the 9Fh wrap, at the unused and serial-number locations, and across the 07h/08h edge tell the zone guards and the hold request apart. A power fail in the middle of a burst checks the abort and that the slave recovers afterwards.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } bus_state_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WORD,
    RX_DATA
  } rx_kind_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/rtcbus_sync.sv
module rtcbus_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{INIT}};
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rtcbus_ptr.sv
module rtcbus_ptr #(
  parameter int          AW      = 8,
  parameter logic [AW-1:0] TOP     = 8'h9F,
  parameter logic [AW-1:0] CLK_TOP = 8'h07,
  parameter logic [AW-1:0] GAP0_LO = 8'h10,
  parameter logic [AW-1:0] GAP0_HI = 8'h12,
  parameter logic [AW-1:0] ROM_LO  = 8'h16,
  parameter logic [AW-1:0] ROM_HI  = 8'h1D,
  parameter logic [AW-1:0] GAP1_LO = 8'h1E,
  parameter logic [AW-1:0] GAP1_HI = 8'h1F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr,
  output logic          in_clock,
  output logic          wr_ok,
  output logic          rd_ok
);
  logic in_gap, in_rom;

  always_ff @(posedge clk) begin
    if (rst || clr)  ptr <= '0;
    else if (load)   ptr <= (load_val > TOP) ? '0 : load_val;
    else if (inc)    ptr <= (ptr == TOP) ? '0 : ptr + 1'b1;
  end

  always_comb begin
    in_gap   = ((ptr >= GAP0_LO) && (ptr <= GAP0_HI)) ||
               ((ptr >= GAP1_LO) && (ptr <= GAP1_HI));
    in_rom   = (ptr >= ROM_LO) && (ptr <= ROM_HI);
    in_clock = (ptr <= CLK_TOP);
    rd_ok    = !in_gap;
    wr_ok    = !in_gap && !in_rom;
  end
endmodule

// File: rtl/rtcbus_slave.sv
module rtcbus_slave
  import rtcbus_pkg::*;
#(
  parameter logic [6:0]    DEV_ADDR    = 7'h68,
  parameter int            AW          = 8,
  parameter logic [AW-1:0] MEM_TOP     = 8'h9F,
  parameter logic [AW-1:0] CLK_TOP     = 8'h07,
  parameter int            SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pwr_fail,
  output logic [AW-1:0]     reg_addr,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              clk_hold
);
  localparam int BCW = $clog2(BYTE_W);

  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  rtcbus_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_scl (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s));
  rtcbus_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sda (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  logic          p_load, p_inc;
  logic [AW-1:0] p_val, ptr;
  logic          in_clock, wr_ok, rd_ok;

  rtcbus_ptr #(.AW(AW), .TOP(MEM_TOP), .CLK_TOP(CLK_TOP)) u_ptr (
    .clk(clk), .rst(rst), .clr(pwr_fail), .load(p_load), .load_val(p_val),
    .inc(p_inc), .ptr(ptr), .in_clock(in_clock), .wr_ok(wr_ok), .rd_ok(rd_ok));

  bus_state_t        state;
  rx_kind_t          kind;
  logic [BCW-1:0]    bitcnt;
  logic [BYTE_W-1:0] shreg, txsh, rd_byte;
  logic              got_byte, rw, in_txn, mack;

  assign rd_byte = rd_ok ? reg_rdata : '0;

  always_ff @(posedge clk) begin
    reg_we <= 1'b0;
    p_load <= 1'b0;
    p_inc  <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= RX_DEV;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      got_byte  <= 1'b0;
      rw        <= 1'b0;
      in_txn    <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_wdata <= '0;
      p_val     <= '0;
    end else if (pwr_fail) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
      in_txn   <= 1'b0;
      got_byte <= 1'b0;
      bitcnt   <= '0;
    end else if (bus_stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      in_txn <= 1'b0;
    end else if (bus_start) begin
      state    <= ST_RX;
      kind     <= RX_DEV;
      bitcnt   <= '0;
      got_byte <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BCW'(BYTE_W - 1)) got_byte <= 1'b1;
          end else if (scl_fall && got_byte) begin
            got_byte <= 1'b0;
            case (kind)
              RX_DEV: begin
                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  in_txn <= 1'b1;
                  state  <= ST_RXACK;
                end else begin
                  state <= ST_SKIP;
                end
              end
              RX_WORD: begin
                p_val  <= AW'(shreg);
                p_load <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_RXACK;
              end
              default: begin
                reg_we    <= wr_ok;
                reg_wdata <= shreg;
                sda_oe    <= 1'b1;
                state     <= ST_RXACK;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_rise && kind == RX_DATA) p_inc <= 1'b1;
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            if (kind == RX_DEV && rw) begin
              state  <= ST_TX;
              txsh   <= {rd_byte[BYTE_W-2:0], 1'b0};
              sda_oe <= ~rd_byte[BYTE_W-1];
            end else begin
              state <= ST_RX;
              kind  <= (kind == RX_DEV) ? RX_WORD : RX_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == BCW'(BYTE_W - 1)) begin
              sda_oe <= 1'b0;
              state  <= ST_TXACK;
            end else begin
              sda_oe <= ~txsh[BYTE_W-1];
              txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            p_inc <= 1'b1;
            mack  <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mack) begin
              state  <= ST_TX;
              txsh   <= {rd_byte[BYTE_W-2:0], 1'b0};
              sda_oe <= ~rd_byte[BYTE_W-1];
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_hold <= 1'b0;
    else     clk_hold <= in_txn && in_clock;
  end

  assign reg_addr = ptr;
endmodule

// File: rtl/rtcbus_slave_chk.sv
module rtcbus_slave_chk #(
  parameter int            AW      = 8,
  parameter logic [AW-1:0] MEM_TOP = 8'h9F,
  parameter logic [AW-1:0] CLK_TOP = 8'h07
) (
  input logic          clk,
  input logic          rst,
  input logic          pwr_fail,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          clk_hold,
  input logic          scl_s
);
  a_r12_pf_release: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> (!sda_oe && reg_addr == '0 && !reg_we));

  a_r9_no_guarded_write: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !((reg_addr >= 8'h10 && reg_addr <= 8'h12) ||
                 (reg_addr >= 8'h16 && reg_addr <= 8'h1F)));

  a_r7_ptr_in_map: assert property (@(posedge clk) disable iff (rst)
    reg_addr <= MEM_TOP);

  a_r11_hold_range: assert property (@(posedge clk) disable iff (rst)
    (reg_addr > CLK_TOP) |=> !clk_hold);

  a_r13_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(pwr_fail)) |-> !scl_s);

  a_r3_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
endmodule

bind rtcbus_slave rtcbus_slave_chk #(.AW(AW), .MEM_TOP(MEM_TOP), .CLK_TOP(CLK_TOP)) chk_i (
  .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_addr(reg_addr), .clk_hold(clk_hold), .scl_s(scl_s));

// File: tb/rtcbus_slave_tb.sv
module rtcbus_slave_tb_top;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       pwr_fail = 1'b0;
  logic       sda_oe, reg_we, clk_hold, sda_line;
  logic [7:0] reg_addr, reg_wdata;
  logic [7:0] reg_rdata = 8'h00;

  logic [7:0] mem [0:159];
  logic       pre_we = 1'b0;
  logic [7:0] pre_addr = 8'h00, pre_data = 8'h00;
  int         rom_hits = 0;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  rtcbus_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_hold(clk_hold));

  initial for (int i = 0; i < 160; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
    else if (reg_we && reg_addr < 8'd160) mem[reg_addr] <= reg_wdata;
    if (reg_we && reg_addr >= 8'h10 && reg_addr <= 8'h1F) rom_hits <= rom_hits + 1;
    reg_rdata <= (reg_addr < 8'd160) ? mem[reg_addr] : 8'h00;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_addr = a; pre_data = d; pre_we = 1'b1;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      d[i] = x;
    end
    bit_out(~give_ack);
  endtask

  task automatic t_reset;
    check("R13 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    check("R13 reset reg_addr", reg_addr, 8'h00);
    check("R13 reset clk_hold", {7'd0, clk_hold}, 8'h00);
    check("R13 reset reg_we", {7'd0, reg_we}, 8'h00);
  endtask

  task automatic t_write_burst;
    logic a;
    logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    bus_start;
    send_byte(8'hD0, a); check("R1 ack of D0h", {7'd0, a}, 8'h01);
    send_byte(8'h20, a); check("R3 ack of word address", {7'd0, a}, 8'h01);
    for (int i = 0; i < 4; i++) begin
      send_byte(d[i], a); check("R3 ack of data byte", {7'd0, a}, 8'h01);
    end
    check("R4 pointer after four writes", reg_addr, 8'h24);
    bus_stop;
    for (int i = 0; i < 4; i++) check("R3 written byte", mem[8'h20 + i], d[i]);
  endtask

  task automatic t_random_read;
    logic a;
    logic [7:0] r;
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h20, a);
    bus_start;
    send_byte(8'hD1, a); check("R2 ack after repeated START", {7'd0, a}, 8'h01);
    recv_byte(1'b1, r); check("R5 first read byte", r, 8'h11);
    recv_byte(1'b1, r); check("R5 second read byte", r, 8'h22);
    recv_byte(1'b0, r); check("R5 third read byte", r, 8'h33);
    bus_stop;
    check("R4 pointer steps on NACKed byte", reg_addr, 8'h23);
  endtask

  task automatic t_current_read;
    logic a;
    logic [7:0] r;
    bus_start;
    send_byte(8'hD1, a); check("R6 ack of D1h", {7'd0, a}, 8'h01);
    recv_byte(1'b0, r); check("R6 current-address byte", r, 8'h44);
    bus_stop;
  endtask

  task automatic t_bad_addr;
    logic a;
    bus_start;
    send_byte(8'hA0, a); check("R1 foreign address not acked", {7'd0, a}, 8'h00);
    send_byte(8'h20, a); check("R1 later byte ignored", {7'd0, a}, 8'h00);
    bus_stop;
    check("R1 pointer untouched", reg_addr, 8'h24);
  endtask

  task automatic t_nack_skip;
    logic a;
    logic [7:0] r;
    preload(8'h30, 8'h00);
    preload(8'h31, 8'h00);
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h30, a);
    bus_start;
    send_byte(8'hD1, a);
    recv_byte(1'b0, r); check("R10 byte before NACK", r, 8'h00);
    recv_byte(1'b0, r); check("R10 SDA released after NACK", r, 8'hFF);
    bus_stop;
  endtask

  task automatic t_wrap;
    logic a;
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h9F, a);
    send_byte(8'h5A, a);
    send_byte(8'h6B, a);
    bus_stop;
    check("R7 byte at 9Fh", mem[8'h9F], 8'h5A);
    check("R7 byte after wrap at 00h", mem[0], 8'h6B);
    check("R7 pointer after wrap", reg_addr, 8'h01);
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'hC5, a);
    bus_stop;
    check("R7 oversize word address", reg_addr, 8'h00);
  endtask

  task automatic t_reserved;
    logic a;
    logic [7:0] r;
    preload(8'h11, 8'hFF);
    preload(8'h16, 8'hA5);
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h11, a);
    bus_start;
    send_byte(8'hD1, a);
    recv_byte(1'b0, r); check("R8 unused location reads 00h", r, 8'h00);
    bus_stop;
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h16, a);
    send_byte(8'h3C, a);
    bus_stop;
    check("R9 serial byte kept", mem[8'h16], 8'hA5);
    check("R9 pointer still advances", reg_addr, 8'h17);
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h11, a);
    send_byte(8'h5E, a);
    bus_stop;
    check("R9 unused location kept", mem[8'h11], 8'hFF);
    check("R9 no guarded strobe", 8'(rom_hits), 8'h00);
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h16, a);
    bus_start;
    send_byte(8'hD1, a);
    recv_byte(1'b0, r); check("R8 serial byte readable", r, 8'hA5);
    bus_stop;
  endtask

  task automatic t_hold;
    logic a;
    logic [7:0] r;
    check("R11 hold low when idle", {7'd0, clk_hold}, 8'h00);
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h06, a);
    check("R11 hold on clock location", {7'd0, clk_hold}, 8'h01);
    bus_start;
    send_byte(8'hD1, a);
    recv_byte(1'b1, r);
    check("R11 hold at 07h", {7'd0, clk_hold}, 8'h01);
    recv_byte(1'b1, r);
    check("R11 hold drops past 07h", {7'd0, clk_hold}, 8'h00);
    recv_byte(1'b0, r);
    bus_stop;
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h03, a);
    check("R11 hold set again", {7'd0, clk_hold}, 8'h01);
    bus_stop;
    check("R11 hold drops on STOP", {7'd0, clk_hold}, 8'h00);
  endtask

  task automatic t_pwrfail;
    logic a;
    bus_start;
    send_byte(8'hD0, a);
    send_byte(8'h40, a);
    send_byte(8'h77, a);
    check("R12 pointer before fail", reg_addr, 8'h41);
    @(negedge clk); pwr_fail = 1'b1;
    wq(3);
    check("R12 SDA released", {7'd0, sda_oe}, 8'h00);
    check("R12 pointer cleared", reg_addr, 8'h00);
    check("R12 hold low", {7'd0, clk_hold}, 8'h00);
    bus_stop;
    bus_start;
    send_byte(8'hD0, a); check("R12 no ack while failing", {7'd0, a}, 8'h00);
    send_byte(8'h50, a);
    send_byte(8'hEE, a);
    bus_stop;
    check("R12 no write while failing", mem[8'h50], 8'h00);
    @(negedge clk); pwr_fail = 1'b0;
    wq(4);
    bus_start;
    send_byte(8'hD0, a); check("R12 ack after recovery", {7'd0, a}, 8'h01);
    send_byte(8'h50, a);
    send_byte(8'h99, a);
    bus_stop;
    check("R12 write after recovery", mem[8'h50], 8'h99);
  endtask

  initial begin
    wq(5);
    rst = 1'b0;
    wq(5);
    t_reset;
    t_write_burst;
    t_random_read;
    t_current_read;
    t_bad_addr;
    t_nack_skip;
    t_wrap;
    t_reserved;
    t_hold;
    t_pwrfail;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule